// File: doc/BRIEF.md
# Character LCD Host Initialization Sequencer

This block lives on the host side of a parallel character-LCD link and owns the whole write path to the display. After reset it waits for the panel's supply to settle, then plays a fixed power-on command sequence: function set, display control, clear, and entry mode. It waits a fixed, command-specific time after each command and never polls the busy flag.

Once the sequence has finished, the block accepts character bytes on a valid/ready handshake and writes each one into display RAM. It generates the register-select, read/write and enable lines and the data bus. Every minimum time is derived from the clock-frequency parameter and rounded up to whole cycles. A parameter selects one of two bus widths:

- **8-bit bus:** each byte goes out in a single enable strobe.
- **4-bit bus:** a lone mode nibble comes first, and every byte after it travels as two enable strobes on the upper four data lines.

Top module: `lcd_init_seq`

## Requirements
- R1: While reset is asserted, and during the power-up wait that follows it, `lcd_e`, `char_ready` and `init_done` are all low.
- R2: The first rising edge of `lcd_e` comes at least 30 ms after reset is released.
- R3: In 8-bit mode the four commands are sent with RS=0 and R/W=0, in this order: function set 0x38 (8-bit, two lines, 5x8 font), display control 0x0C (display on, cursor off, blink off), clear 0x01, and entry mode 0x06 (increment, no shift).
- R4: The time from the falling edge of E for a command to the next rising edge of E is at least 40 µs after function set and after display control, and at least 1.64 ms after clear.
- R5: E stays high for at least 300 ns, and consecutive rising edges of E are at least 500 ns apart.
- R6: RS and R/W settle at least 60 ns before E rises on the 8-bit bus and at least 100 ns before on the 4-bit bus. RS, R/W and the data bus do not change within 10 ns after E falls.
- R7: The data bus is stable from at least 100 ns before E falls, and it does not change while E is high.
- R8: In 4-bit mode the bus carries nibbles on DB7..DB4 and holds DB3..DB0 at zero. The first strobe is the lone nibble 0010. Then follow 0x28, 0x0C, 0x01 and 0x06, each sent high nibble first and low nibble second, with 40 µs after the lone nibble.
- R9: `char_ready` is high only after `init_done` has risen and while no transfer and no post-write wait is in progress. It drops in the cycle after a byte is accepted. `init_done` stays high once it has risen.
- R10: An accepted character is written with RS=1 and R/W=0, carrying the accepted byte (as two nibbles on the 4-bit bus). At least 40 µs pass before the next strobe, and no strobe appears while no byte is offered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock whose frequency is given by `CLK_HZ` |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| char_data | input | 8 | Character code to write to display RAM |
| char_valid | input | 1 | A character is offered on `char_data` |
| char_ready | output | 1 | The block takes the offered character on this cycle |
| init_done | output | 1 | The power-on command sequence has finished |
| lcd_rs | output | 1 | Register select: 0 command, 1 display data |
| lcd_rw | output | 1 | Read/write select, always write (0) |
| lcd_e | output | 1 | Enable strobe |
| lcd_db | output | 8 | Data bus. In 4-bit mode only bits 7..4 carry data |

## Verification
The embedded properties assume that `char_valid` and `char_data` are driven from the same clock domain and change only away from the sampling edge. They also assume that `CLK_HZ` matches the real clock, because every nanosecond minimum is checked in cycles derived from it.

The stimulus meets these assumptions as follows. It drives the handshake half a period after each rising edge and offers a byte only after it has seen `char_ready` high. It runs both bus widths at 4 MHz, which turns every bus minimum into one or two cycles while keeping the 30 ms power-up wait affordable. A passive probe on each bus measures the real intervals in nanoseconds, so its checks do not depend on how the design rounds.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

  typedef enum logic [2:0] {SQ_BOOT, SQ_WAIT, SQ_ISSUE, SQ_XFER, SQ_READY} sq_state_e;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_HIGH, PH_LOW} ph_e;

  typedef enum logic {POST_SHORT, POST_LONG} post_e;

  typedef struct packed {
    logic       rs;
    logic       single;
    logic [7:0] data;
  } xfer_t;

  // Minimum time in ns converted to clock cycles, rounded up, never below one.
  function automatic longint cycles_ceil(input longint ns, input longint hz);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return c;
  endfunction

endpackage

// File: rtl/lcd_rst_sync.sv
module lcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/lcd_delay.sv
module lcd_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] count,
  output logic         busy
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = load || busy;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = count;
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  AST_DLY_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy) else $error("delay reloaded while running"); // R4
  AST_DLY_LOAD_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> count != '0) else $error("zero-length delay"); // R4
  AST_DLY_RUNS_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy) else $error("delay did not start"); // R4
endmodule

// File: rtl/lcd_strobe.sv
module lcd_strobe
  import lcd_seq_pkg::*;
#(
  parameter bit NIBBLE = 1'b0,
  parameter int AS_CYC = 1,
  parameter int PW_CYC = 1,
  parameter int LO_CYC = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  xfer_t       req,
  output logic        lcd_rs,
  output logic        lcd_rw,
  output logic        lcd_e,
  output logic [7:0]  lcd_db,
  output logic        busy
);
  localparam int MAXC = (AS_CYC > PW_CYC) ? ((AS_CYC > LO_CYC) ? AS_CYC : LO_CYC)
                                          : ((PW_CYC > LO_CYC) ? PW_CYC : LO_CYC);
  localparam int CW   = $clog2(MAXC + 1);
  localparam int HW   = $clog2(PW_CYC + 2);

  ph_e          ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic         sec_q, sec_d;
  logic         single_q, single_d;
  logic [7:0]   data_q, data_d;
  logic         rs_q, rs_d;
  logic         e_q, e_d;
  logic [7:0]   db_q, db_d;
  logic         ph_en;
  logic [7:0]   first_db, second_db;
  logic         two_phase;

  generate
    if (NIBBLE) begin : g_nib
      assign first_db  = {req.data[7:4], 4'b0000};
      assign second_db = {data_q[3:0], 4'b0000};
    end else begin : g_byte
      assign first_db  = req.data;
      assign second_db = data_q;
    end
  endgenerate

  assign two_phase = NIBBLE && !single_q && !sec_q;
  assign ph_en     = (ph_q != PH_IDLE) || start;

  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    sec_d    = sec_q;
    single_d = single_q;
    data_d   = data_q;
    rs_d     = rs_q;
    e_d      = e_q;
    db_d     = db_q;
    case (ph_q)
      PH_IDLE: if (start) begin
        single_d = req.single;
        data_d   = req.data;
        rs_d     = req.rs;
        db_d     = first_db;
        sec_d    = 1'b0;
        ph_d     = PH_SETUP;
        cnt_d    = CW'(AS_CYC - 1);
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          ph_d  = PH_HIGH;
          cnt_d = CW'(PW_CYC - 1);
          e_d   = 1'b1;
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_HIGH: begin
        if (cnt_q == '0) begin
          ph_d  = PH_LOW;
          cnt_d = CW'(LO_CYC - 1);
          e_d   = 1'b0;
        end else cnt_d = cnt_q - 1'b1;
      end
      PH_LOW: begin
        if (cnt_q == '0) begin
          if (two_phase) begin
            sec_d = 1'b1;
            db_d  = second_db;
            ph_d  = PH_SETUP;
            cnt_d = CW'(AS_CYC - 1);
          end else ph_d = PH_IDLE;
        end else cnt_d = cnt_q - 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      sec_q    <= 1'b0;
      single_q <= 1'b0;
      data_q   <= '0;
      rs_q     <= 1'b0;
      e_q      <= 1'b0;
      db_q     <= '0;
    end else if (ph_en) begin
      ph_q     <= ph_d;
      cnt_q    <= cnt_d;
      sec_q    <= sec_d;
      single_q <= single_d;
      data_q   <= data_d;
      rs_q     <= rs_d;
      e_q      <= e_d;
      db_q     <= db_d;
    end
  end

  assign lcd_rs = rs_q;
  assign lcd_rw = 1'b0;
  assign lcd_e  = e_q;
  assign lcd_db = db_q;
  assign busy   = (ph_q != PH_IDLE);

  // Checker state: length of the current E-high pulse.
  logic [HW-1:0] hi_len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         hi_len_q <= '0;
    else if (!e_q)                      hi_len_q <= '0;
    else if (hi_len_q != {HW{1'b1}})    hi_len_q <= hi_len_q + 1'b1;
  end

  AST_E_PULSE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_q) |-> hi_len_q >= HW'(PW_CYC)) else $error("E pulse short"); // R5
  AST_BUS_STABLE_E_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    e_q |-> $stable(rs_q) && $stable(db_q)) else $error("bus moved with E high"); // R7
  AST_HOLD_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(e_q) |-> $stable(rs_q) && $stable(db_q)) else $error("no hold after E fall"); // R6
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy) else $error("start while busy"); // R9
endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_seq_pkg::*;
#(
  parameter longint CLK_HZ    = 50_000_000,
  parameter bit     NIBBLE    = 1'b0,
  parameter bit     TWO_LINE  = 1'b1,
  parameter bit     TALL_FONT = 1'b0,
  parameter bit     CURSOR_ON = 1'b0,
  parameter bit     BLINK_ON  = 1'b0,
  parameter bit     INCREMENT = 1'b1,
  parameter bit     SHIFT_ON  = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] char_data,
  input  logic       char_valid,
  output logic       char_ready,
  output logic       init_done,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_e,
  output logic [7:0] lcd_db
);
  localparam longint PWRUP_CYC = cycles_ceil(30_000_000, CLK_HZ);
  localparam longint CMD_CYC   = cycles_ceil(40_000, CLK_HZ);
  localparam longint CLR_CYC   = cycles_ceil(1_640_000, CLK_HZ);
  localparam longint AS_CYC    = cycles_ceil(NIBBLE ? 100 : 60, CLK_HZ);
  localparam longint PW_CYC    = cycles_ceil(300, CLK_HZ);
  localparam longint ECYC_CYC  = cycles_ceil(500, CLK_HZ);
  localparam longint AH_CYC    = cycles_ceil(10, CLK_HZ);
  localparam longint LO_RAW    = ECYC_CYC - PW_CYC - AS_CYC;
  localparam longint LO_CYC    = (LO_RAW > AH_CYC) ? LO_RAW : AH_CYC;
  localparam int     DW        = $clog2(PWRUP_CYC + 1);
  localparam int     NSTEPS    = NIBBLE ? 5 : 4;
  localparam logic [2:0] LAST_STEP = 3'(NSTEPS);

  localparam logic [7:0] FUNC_B  = {3'b001, ~NIBBLE, TWO_LINE, TALL_FONT, 2'b00};
  localparam logic [7:0] DISP_B  = {5'b00001, 1'b1, CURSOR_ON, BLINK_ON};
  localparam logic [7:0] CLEAR_B = 8'h01;
  localparam logic [7:0] ENTRY_B = {6'b000001, INCREMENT, SHIFT_ON};
  localparam logic [7:0] LONE_B  = 8'h20;

  logic srst_n;
  lcd_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  sq_state_e    st_q, st_d;
  logic [2:0]   step_q, step_d;
  logic         done_q, done_d;
  post_e        post_q, post_d;
  logic         dly_load, dly_busy;
  logic [DW-1:0] dly_val;
  logic         x_start, strb_busy;
  xfer_t        x_req, step_req;
  post_e        step_post;
  logic [2:0]   cmd_idx;

  // Command table: the lone mode nibble leads on the 4-bit bus.
  always_comb begin
    cmd_idx   = step_q - {2'b00, NIBBLE};
    step_req  = '{rs: 1'b0, single: 1'b0, data: FUNC_B};
    step_post = POST_SHORT;
    if (NIBBLE && step_q == 3'd0) begin
      step_req = '{rs: 1'b0, single: 1'b1, data: LONE_B};
    end else begin
      case (cmd_idx)
        3'd0:    step_req.data = FUNC_B;
        3'd1:    step_req.data = DISP_B;
        3'd2:    begin step_req.data = CLEAR_B; step_post = POST_LONG; end
        default: step_req.data = ENTRY_B;
      endcase
    end
  end

  always_comb begin
    st_d     = st_q;
    step_d   = step_q;
    done_d   = done_q;
    post_d   = post_q;
    dly_load = 1'b0;
    dly_val  = '0;
    x_start  = 1'b0;
    x_req    = step_req;
    case (st_q)
      SQ_BOOT: begin
        dly_load = 1'b1;
        dly_val  = DW'(PWRUP_CYC);
        st_d     = SQ_WAIT;
      end
      SQ_WAIT: if (!dly_busy) begin
        if (done_q) st_d = SQ_READY;
        else if (step_q == LAST_STEP) begin
          done_d = 1'b1;
          st_d   = SQ_READY;
        end else st_d = SQ_ISSUE;
      end
      SQ_ISSUE: begin
        x_start = 1'b1;
        post_d  = step_post;
        st_d    = SQ_XFER;
      end
      SQ_XFER: if (!strb_busy) begin
        dly_load = 1'b1;
        dly_val  = (post_q == POST_LONG) ? DW'(CLR_CYC) : DW'(CMD_CYC);
        st_d     = SQ_WAIT;
        if (!done_q) step_d = step_q + 3'd1;
      end
      SQ_READY: if (char_valid) begin
        x_start = 1'b1;
        x_req   = '{rs: 1'b1, single: 1'b0, data: char_data};
        post_d  = POST_SHORT;
        st_d    = SQ_XFER;
      end
      default: st_d = SQ_BOOT;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= SQ_BOOT;
      step_q <= '0;
      done_q <= 1'b0;
      post_q <= POST_SHORT;
    end else begin
      st_q   <= st_d;
      step_q <= step_d;
      done_q <= done_d;
      post_q <= post_d;
    end
  end

  lcd_delay #(.W(DW)) u_dly (
    .clk(clk), .rst_n(srst_n), .load(dly_load), .count(dly_val), .busy(dly_busy)
  );

  lcd_strobe #(
    .NIBBLE(NIBBLE), .AS_CYC(int'(AS_CYC)), .PW_CYC(int'(PW_CYC)), .LO_CYC(int'(LO_CYC))
  ) u_strb (
    .clk(clk), .rst_n(srst_n), .start(x_start), .req(x_req),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_e(lcd_e), .lcd_db(lcd_db), .busy(strb_busy)
  );

  assign char_ready = (st_q == SQ_READY);
  assign init_done  = done_q;

  AST_READY_AFTER_INIT: assert property (@(posedge clk) disable iff (!srst_n)
    char_ready |-> init_done) else $error("ready before init"); // R9
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!srst_n)
    char_ready |-> !strb_busy && !dly_busy) else $error("ready during activity"); // R9
  AST_ACCEPT_STARTS_WRITE: assert property (@(posedge clk) disable iff (!srst_n)
    char_valid && char_ready |=> !char_ready && strb_busy) else $error("accept lost"); // R10
  AST_INIT_DONE_STICKY: assert property (@(posedge clk) disable iff (!srst_n)
    init_done |=> init_done) else $error("init_done dropped"); // R9
  AST_NO_E_BEFORE_INIT_WAIT: assert property (@(posedge clk) disable iff (!srst_n)
    (st_q == SQ_BOOT) |-> !lcd_e) else $error("E during boot"); // R1
endmodule

// File: tb/tb_lcd_init_seq.sv
`timescale 1ns/1ps
module lcd_bus_probe #(
  parameter longint PERIOD_NS  = 250,
  parameter longint MIN_AS_NS  = 60
) (
  input logic       clk,
  input logic       rs,
  input logic       rw,
  input logic       e,
  input logic [7:0] db
);
  longint cyc = 0;
  int     n = 0;
  logic [7:0] db_log [0:31];
  logic       rs_log [0:31];
  logic       rw_log [0:31];
  longint     rise_log [0:31];
  longint     fall_log [0:31];
  int viol_pw = 0, viol_cyc = 0, viol_as = 0, viol_hold = 0, viol_ds = 0;
  logic p_e = 1'b0, p_rs = 1'b0, p_rw = 1'b0;
  logic [7:0] p_db = 8'h00;
  longint last_ctl = 0, last_db = 0, last_rise = 0;
  bit seen_rise = 0;

  always @(negedge clk) begin
    bit fell_now, rose_now;
    cyc = cyc + 1;
    fell_now = !e && p_e;
    rose_now = e && !p_e;
    if (rs !== p_rs || rw !== p_rw) begin
      if (fell_now) viol_hold++;
      last_ctl = cyc;
    end
    if (db !== p_db) begin
      if (fell_now) viol_hold++;
      if (e && p_e) viol_ds++;
      last_db = cyc;
    end
    if (rose_now) begin
      if ((cyc - last_ctl) * PERIOD_NS < MIN_AS_NS) viol_as++;
      if (seen_rise && (cyc - last_rise) * PERIOD_NS < 500) viol_cyc++;
      last_rise = cyc;
      seen_rise = 1;
      if (n < 32) rise_log[n] = cyc;
    end
    if (fell_now) begin
      if ((cyc - last_rise) * PERIOD_NS < 300) viol_pw++;
      if ((cyc - last_db) * PERIOD_NS < 100) viol_ds++;
      if (n < 32) begin
        fall_log[n] = cyc; db_log[n] = db; rs_log[n] = rs; rw_log[n] = rw;
      end
      n++;
    end
    p_e = e; p_rs = rs; p_rw = rw; p_db = db;
  end
endmodule

module tb_lcd_init_seq;
  localparam longint CLK_PERIOD = 250;
  localparam longint HZ = 4_000_000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] data_b = 8'h00, data_n = 8'h00;
  logic valid_b = 1'b0, valid_n = 1'b0;
  logic rdy_b, rdy_n, done_b, done_n;
  logic rs_b, rw_b, e_b, rs_n, rw_n, e_n;
  logic [7:0] db_b, db_n;
  int tests = 0, fails = 0;
  longint rel_cyc = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_init_seq #(.CLK_HZ(HZ), .NIBBLE(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .char_data(data_b), .char_valid(valid_b),
    .char_ready(rdy_b), .init_done(done_b), .lcd_rs(rs_b), .lcd_rw(rw_b),
    .lcd_e(e_b), .lcd_db(db_b));

  lcd_init_seq #(.CLK_HZ(HZ), .NIBBLE(1'b1)) dut_nib (
    .clk(clk), .rst_n(rst_n), .char_data(data_n), .char_valid(valid_n),
    .char_ready(rdy_n), .init_done(done_n), .lcd_rs(rs_n), .lcd_rw(rw_n),
    .lcd_e(e_n), .lcd_db(db_n));

  lcd_bus_probe #(.PERIOD_NS(CLK_PERIOD), .MIN_AS_NS(60)) mon_b (
    .clk(clk), .rs(rs_b), .rw(rw_b), .e(e_b), .db(db_b));
  lcd_bus_probe #(.PERIOD_NS(CLK_PERIOD), .MIN_AS_NS(100)) mon_n (
    .clk(clk), .rs(rs_n), .rw(rw_n), .e(e_n), .db(db_n));

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(e_b == 0 && e_n == 0, "R1", "E low in reset", e_b, 0);
    chk(rdy_b == 0 && rdy_n == 0, "R1", "ready low in reset", rdy_b, 0);
    chk(done_b == 0 && done_n == 0, "R1", "init_done low in reset", done_b, 0);
    #1 rst_n = 1'b1;
    rel_cyc = mon_b.cyc;
    repeat (1000) @(negedge clk);
    chk(e_b == 0 && e_n == 0 && rdy_b == 0 && rdy_n == 0 && done_b == 0,
        "R1", "quiet during power-up wait", e_b, 0);
  endtask

  task automatic t_init_bus8();
    logic [7:0] exp_b [0:3];
    exp_b = '{8'h38, 8'h0C, 8'h01, 8'h06};
    while (!done_b) @(negedge clk);
    chk(mon_b.n == 4, "R3", "command strobe count", mon_b.n, 4);
    chk((mon_b.rise_log[0] - rel_cyc) * CLK_PERIOD >= 30_000_000, "R2", "power-up wait ns",
        (mon_b.rise_log[0] - rel_cyc) * CLK_PERIOD, 30_000_000);
    for (int i = 0; i < 4; i++) begin
      chk(mon_b.db_log[i] == exp_b[i], "R3", "command byte", mon_b.db_log[i], exp_b[i]);
      chk(mon_b.rs_log[i] == 0 && mon_b.rw_log[i] == 0, "R3", "command RS/RW",
          {mon_b.rs_log[i], mon_b.rw_log[i]}, 0);
    end
    for (int i = 0; i < 3; i++) begin
      longint gap = (mon_b.rise_log[i+1] - mon_b.fall_log[i]) * CLK_PERIOD;
      longint need = (i == 2) ? 1_640_000 : 40_000;
      chk(gap >= need, "R4", "post-command wait ns", gap, need);
    end
    chk(rdy_b == 1, "R9", "ready after init", rdy_b, 1);
  endtask

  task automatic t_init_bus4();
    logic [7:0] exp_n [0:8];
    exp_n = '{8'h20, 8'h20, 8'h80, 8'h00, 8'hC0, 8'h00, 8'h10, 8'h00, 8'h60};
    while (!done_n) @(negedge clk);
    chk(mon_n.n == 9, "R8", "nibble strobe count", mon_n.n, 9);
    chk((mon_n.rise_log[0] - rel_cyc) * CLK_PERIOD >= 30_000_000, "R2", "power-up wait 4-bit",
        (mon_n.rise_log[0] - rel_cyc) * CLK_PERIOD, 30_000_000);
    for (int i = 0; i < 9; i++) begin
      chk(mon_n.db_log[i] == exp_n[i], "R8", "nibble on DB7..DB4", mon_n.db_log[i], exp_n[i]);
      chk(mon_n.rs_log[i] == 0 && mon_n.rw_log[i] == 0, "R8", "nibble RS/RW",
          {mon_n.rs_log[i], mon_n.rw_log[i]}, 0);
    end
    chk((mon_n.rise_log[1] - mon_n.fall_log[0]) * CLK_PERIOD >= 40_000, "R8", "wait after lone nibble",
        (mon_n.rise_log[1] - mon_n.fall_log[0]) * CLK_PERIOD, 40_000);
    chk((mon_n.rise_log[3] - mon_n.fall_log[2]) * CLK_PERIOD >= 40_000, "R4", "wait after function set",
        (mon_n.rise_log[3] - mon_n.fall_log[2]) * CLK_PERIOD, 40_000);
    chk((mon_n.rise_log[5] - mon_n.fall_log[4]) * CLK_PERIOD >= 40_000, "R4", "wait after display ctl",
        (mon_n.rise_log[5] - mon_n.fall_log[4]) * CLK_PERIOD, 40_000);
    chk((mon_n.rise_log[7] - mon_n.fall_log[6]) * CLK_PERIOD >= 1_640_000, "R4", "wait after clear",
        (mon_n.rise_log[7] - mon_n.fall_log[6]) * CLK_PERIOD, 1_640_000);
  endtask

  task automatic send_char(input bit nib, input logic [7:0] b);
    if (!nib) begin
      while (!rdy_b) @(negedge clk);
      data_b = b; valid_b = 1'b1;
      @(negedge clk);
      valid_b = 1'b0;
      chk(rdy_b == 0, "R9", "ready drops after accept", rdy_b, 0);
    end else begin
      while (!rdy_n) @(negedge clk);
      data_n = b; valid_n = 1'b1;
      @(negedge clk);
      valid_n = 1'b0;
      chk(rdy_n == 0, "R9", "ready drops after accept", rdy_n, 0);
    end
  endtask

  task automatic t_chars_bus8();
    logic [7:0] c [0:2];
    c = '{8'h48, 8'hA5, 8'h00};
    repeat (500) @(negedge clk);
    chk(mon_b.n == 4, "R10", "no strobe without valid", mon_b.n, 4);
    for (int i = 0; i < 3; i++) send_char(1'b0, c[i]);
    while (!rdy_b) @(negedge clk);
    chk(mon_b.n == 7, "R10", "char strobe count", mon_b.n, 7);
    for (int i = 0; i < 3; i++) begin
      chk(mon_b.db_log[4+i] == c[i], "R10", "char byte", mon_b.db_log[4+i], c[i]);
      chk(mon_b.rs_log[4+i] == 1 && mon_b.rw_log[4+i] == 0, "R10", "char RS/RW",
          {mon_b.rs_log[4+i], mon_b.rw_log[4+i]}, 2);
    end
    for (int i = 4; i < 6; i++)
      chk((mon_b.rise_log[i+1] - mon_b.fall_log[i]) * CLK_PERIOD >= 40_000, "R10", "wait after char",
          (mon_b.rise_log[i+1] - mon_b.fall_log[i]) * CLK_PERIOD, 40_000);
  endtask

  task automatic t_chars_bus4();
    logic [7:0] exp_n [0:3];
    exp_n = '{8'h40, 8'h80, 8'h30, 8'hC0};
    send_char(1'b1, 8'h48);
    send_char(1'b1, 8'h3C);
    while (!rdy_n) @(negedge clk);
    chk(mon_n.n == 13, "R10", "4-bit char strobe count", mon_n.n, 13);
    for (int i = 0; i < 4; i++) begin
      chk(mon_n.db_log[9+i] == exp_n[i], "R8", "char nibble order", mon_n.db_log[9+i], exp_n[i]);
      chk(mon_n.rs_log[9+i] == 1 && mon_n.rw_log[9+i] == 0, "R10", "4-bit char RS/RW",
          {mon_n.rs_log[9+i], mon_n.rw_log[9+i]}, 2);
    end
    chk((mon_n.rise_log[11] - mon_n.fall_log[10]) * CLK_PERIOD >= 40_000, "R10", "4-bit wait after char",
        (mon_n.rise_log[11] - mon_n.fall_log[10]) * CLK_PERIOD, 40_000);
  endtask

  task automatic t_timing();
    chk(mon_b.viol_pw == 0 && mon_n.viol_pw == 0, "R5", "E high width", mon_b.viol_pw + mon_n.viol_pw, 0);
    chk(mon_b.viol_cyc == 0 && mon_n.viol_cyc == 0, "R5", "E cycle", mon_b.viol_cyc + mon_n.viol_cyc, 0);
    chk(mon_b.viol_as == 0, "R6", "8-bit RS setup", mon_b.viol_as, 0);
    chk(mon_n.viol_as == 0, "R6", "4-bit RS setup", mon_n.viol_as, 0);
    chk(mon_b.viol_hold == 0 && mon_n.viol_hold == 0, "R6", "hold after E fall",
        mon_b.viol_hold + mon_n.viol_hold, 0);
    chk(mon_b.viol_ds == 0 && mon_n.viol_ds == 0, "R7", "data setup", mon_b.viol_ds + mon_n.viol_ds, 0);
  endtask

  initial begin
    t_reset();
    t_init_bus8();
    t_init_bus4();
    t_chars_bus8();
    t_chars_bus4();
    t_timing();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule